// File: doc/BRIEF.md
# Strip Cluster Center Finder

This block turns one clock's worth of already-discriminated cathode strip bits from a single readout plane into a short list of hit positions. Adjacent fired strips are grouped into runs. A run of two or three strips is taken as the footprint of one induced charge. The block reports the geometric center strip of that run as the hit position. It does not weight by charge, because the input carries none. Any run of another length is rejected and raises a flag.

A pattern is presented with `in_valid`. One clock later the block presents a registered result with `out_valid`. The result holds up to `MAX_HITS` hit slots, filled in ascending strip order from slot 0. An overflow flag shows that further valid clusters were found but had no slot. The chosen center lies at most one strip from the true charge peak, which is the resolution this position estimate is meant to give.

Top module: `strip_cluster_finder`

## Requirements
- R1: A run of exactly two adjacent set strips yields one hit whose index is the lower-numbered strip of the pair.
- R2: A run of exactly three adjacent set strips yields one hit whose index is the middle strip.
- R3: A run of one strip, or of four or more strips, yields no hit and sets `bad_run`. Valid runs in the same pattern still yield their hits.
- R4: Hits fill slots from slot 0 upward in ascending strip index, with slot k at `hit_index[k*IDX_W +: IDX_W]`. Unused slots have `hit_valid` low and index 0.
- R5: When more than `MAX_HITS` valid clusters are present, the lowest `MAX_HITS` are reported and `overflow` is set. With exactly `MAX_HITS` clusters, `overflow` stays low.
- R6: A pattern sampled with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high for exactly that cycle.
- R7: After reset, `out_valid`, `hit_valid`, `hit_index`, `overflow` and `bad_run` are all zero.
- R8: Strips outside the plane count as unfired, so runs touching strip 0 or strip `NSTRIP-1` are classified like any other run.
- R9: While `in_valid` is low, `out_valid` is low and the hit, overflow and bad-run outputs hold their last values, whatever `strip_bits` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pattern on `strip_bits` is to be processed |
| strip_bits | input | NSTRIP | Discriminated hit bit per strip, bit i is strip i |
| out_valid | output | 1 | Result registered from the last accepted pattern |
| hit_valid | output | MAX_HITS | Per-slot hit present |
| hit_index | output | MAX_HITS*IDX_W | Center strip index per slot, slot k in bits k*IDX_W upward |
| overflow | output | 1 | More valid clusters than slots |
| bad_run | output | 1 | At least one run of length 1 or of 4 or more |

## Verification
Every result is due at the rising edge that samples `in_valid`, because there is a single register between the pins. The bench drives a pattern on a falling edge and reads the outputs at the following falling edge, half a cycle after they change. Before that edge, it also confirms that nothing has appeared early. One further falling edge later, it checks that `out_valid` has dropped and that the hit fields held while `strip_bits` was scrambled.

// File: rtl/scf_pkg.sv
// Shared types for the strip cluster finder.
// Assumes nothing beyond standard SystemVerilog packages.
package scf_pkg;

    // Classification of the run that starts at a given strip
    typedef enum logic [1:0] {
        RUN_NONE   = 2'd0,  // no run starts here
        RUN_PAIR   = 2'd1,  // run of exactly two strips
        RUN_TRIPLE = 2'd2,  // run of exactly three strips
        RUN_BAD    = 2'd3   // run of one strip, or four and more
    } run_kind_t;

endpackage

// File: rtl/scf_run_detect.sv
// Classifies, for every strip, whether a run of fired strips starts there
// and how long it is. It produces a map with one bit set at the center
// strip of each valid run, plus a flag for any run of illegal length.
// Assumes: strips beyond both ends of the plane are unfired.
module scf_run_detect
    import scf_pkg::*;
#(
    parameter int NSTRIP = 32
) (
    input  logic [NSTRIP-1:0] bits,
    output logic [NSTRIP-1:0] center_map,
    output logic              bad_any
);

    // Padding: one zero below strip 0, three zeros above the top strip
    localparam int EXT_W = NSTRIP + 4;

    logic [EXT_W-1:0]  ext;
    run_kind_t         kind [NSTRIP];
    logic [NSTRIP-1:0] bad_vec;

    assign ext = {3'b000, bits, 1'b0};

    // Per-strip run classifier; ext[i+1] is strip i
    for (genvar i = 0; i < NSTRIP; i++) begin : g_cls
        logic prev, s0, s1, s2, s3;
        assign prev = ext[i];
        assign s0   = ext[i+1];
        assign s1   = ext[i+2];
        assign s2   = ext[i+3];
        assign s3   = ext[i+4];

        // Decide run kind from the starting strip and the three above it
        always_comb begin
            if (!s0 || prev)            kind[i] = RUN_NONE;
            else if (!s1)               kind[i] = RUN_BAD;
            else if (!s2)               kind[i] = RUN_PAIR;
            else if (!s3)               kind[i] = RUN_TRIPLE;
            else                        kind[i] = RUN_BAD;
        end
        assign bad_vec[i] = (kind[i] == RUN_BAD);
    end

    // Center placement: pair -> own strip, triple -> strip above the start
    for (genvar i = 0; i < NSTRIP; i++) begin : g_ctr
        if (i == 0) begin : g_first
            assign center_map[i] = (kind[i] == RUN_PAIR);
        end else begin : g_rest
            assign center_map[i] = (kind[i] == RUN_PAIR) || (kind[i-1] == RUN_TRIPLE);
        end
    end

    assign bad_any = |bad_vec;

    // Guard: a center is always a fired strip and never touches another
    always_comb begin
        // R1
        center_on_fired_chk: assert ((center_map & ~bits) == '0);
        // R2
        center_isolated_chk: assert ((center_map & (center_map >> 1)) == '0);
    end

endmodule

// File: rtl/scf_hit_select.sv
// Picks the lowest MAX_HITS set bits of the center map in ascending order
// and encodes them as strip indices. Flags any centers left over.
// Assumes: the center map has at most one bit per cluster.
module scf_hit_select #(
    parameter int NSTRIP   = 32,
    parameter int MAX_HITS = 4,
    parameter int IDX_W    = $clog2(NSTRIP)
) (
    input  logic [NSTRIP-1:0]         center_map,
    output logic [MAX_HITS-1:0]       hv,
    output logic [MAX_HITS*IDX_W-1:0] hidx,
    output logic                      too_many
);

    // Serial priority pick: each slot takes the lowest remaining center
    always_comb begin
        logic [NSTRIP-1:0] rest;
        logic              found;
        int                pick;
        rest = center_map;
        hv   = '0;
        hidx = '0;
        for (int k = 0; k < MAX_HITS; k++) begin
            found = 1'b0;
            pick  = 0;
            for (int j = 0; j < NSTRIP; j++) begin
                if (!found && rest[j]) begin
                    found = 1'b1;
                    pick  = j;
                end
            end
            if (found) begin
                rest[pick]              = 1'b0;
                hv[k]                   = 1'b1;
                hidx[k*IDX_W +: IDX_W]  = IDX_W'(pick);
            end
        end
        too_many = |rest;
    end

    // Guard: overflow only once every slot is taken
    always_comb begin
        // R5
        spill_needs_full_chk: assert (!too_many || (&hv));
    end

endmodule

// File: rtl/strip_cluster_finder.sv
// Top of the strip cluster center finder. It takes a binary strip pattern,
// finds runs of 2 or 3 fired strips and reports their center strip indices
// one clock after in_valid. Assumes synchronous active-low reset.
module strip_cluster_finder #(
    parameter int NSTRIP   = 32,
    parameter int MAX_HITS = 4,
    parameter int IDX_W    = $clog2(NSTRIP)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NSTRIP-1:0]         strip_bits,
    output logic                      out_valid,
    output logic [MAX_HITS-1:0]       hit_valid,
    output logic [MAX_HITS*IDX_W-1:0] hit_index,
    output logic                      overflow,
    output logic                      bad_run
);

    logic [NSTRIP-1:0]         center_map;
    logic                      bad_any;
    logic [MAX_HITS-1:0]       sel_hv;
    logic [MAX_HITS*IDX_W-1:0] sel_idx;
    logic                      sel_many;

    scf_run_detect #(.NSTRIP(NSTRIP)) u_detect (
        .bits       (strip_bits),
        .center_map (center_map),
        .bad_any    (bad_any)
    );

    scf_hit_select #(.NSTRIP(NSTRIP), .MAX_HITS(MAX_HITS), .IDX_W(IDX_W)) u_select (
        .center_map (center_map),
        .hv         (sel_hv),
        .hidx       (sel_idx),
        .too_many   (sel_many)
    );

    // Valid flag follows in_valid by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result register: loads on accepted patterns, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid <= '0;
            hit_index <= '0;
            overflow  <= 1'b0;
            bad_run   <= 1'b0;
        end else if (in_valid) begin
            hit_valid <= sel_hv;
            hit_index <= sel_idx;
            overflow  <= sel_many;
            bad_run   <= bad_any;
        end
    end

    // R6
    vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(hit_valid) && $stable(hit_index)
                       && $stable(overflow) && $stable(bad_run)));
    // R4
    fill_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((hit_valid & (hit_valid + MAX_HITS'(1))) == '0));
    // R5
    ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (&hit_valid));

    for (genvar k = 0; k < MAX_HITS; k++) begin : g_slot_chk
        // R4
        idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !hit_valid[k] |-> (hit_index[k*IDX_W +: IDX_W] == '0));
        if (k > 0) begin : g_order
            // R4
            ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hit_valid[k] |-> (hit_index[k*IDX_W +: IDX_W]
                                  > hit_index[(k-1)*IDX_W +: IDX_W]));
        end
    end

endmodule

// File: tb/test_strip_cluster_finder.sv
module test_strip_cluster_finder;

    localparam int NS = 32;
    localparam int MH = 4;
    localparam int IW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [NS-1:0]   strip_bits = '0;
    logic            out_valid;
    logic [MH-1:0]   hit_valid;
    logic [MH*IW-1:0] hit_index;
    logic            overflow;
    logic            bad_run;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    strip_cluster_finder #(.NSTRIP(NS), .MAX_HITS(MH), .IDX_W(IW)) i_strip_cluster_finder (
        .clk, .rst_n, .in_valid, .strip_bits,
        .out_valid, .hit_valid, .hit_index, .overflow, .bad_run
    );

    function automatic logic [NS-1:0] run(input int lo, input int hi);
        logic [NS-1:0] v = '0;
        for (int i = lo; i <= hi; i++) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [MH*IW-1:0] idx4(input int a, input int b, input int c, input int d);
        return {IW'(d), IW'(c), IW'(b), IW'(a)};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare the full result set
    task automatic chk_all(input string req, input logic [MH-1:0] hv, input logic [MH*IW-1:0] hi,
                           input logic ov, input logic bd);
        chk(req, "out_valid", 64'(out_valid), 64'd1);
        chk(req, "hit_valid", 64'(hit_valid), 64'(hv));
        chk(req, "hit_index", 64'(hit_index), 64'(hi));
        chk(req, "overflow",  64'(overflow),  64'(ov));
        chk(req, "bad_run",   64'(bad_run),   64'(bd));
    endtask

    // Present one pattern for one cycle; returns at the falling edge where results are due
    task automatic apply(input logic [NS-1:0] p);
        @(negedge clk);
        strip_bits = p;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
        strip_bits = ~p;
    endtask

    task automatic t_reset();
        chk("R7", "out_valid", 64'(out_valid), 64'd0);
        chk("R7", "hit_valid", 64'(hit_valid), 64'd0);
        chk("R7", "hit_index", 64'(hit_index), 64'd0);
        chk("R7", "overflow",  64'(overflow),  64'd0);
        chk("R7", "bad_run",   64'(bad_run),   64'd0);
    endtask

    task automatic t_pair();
        apply(run(5, 6));
        chk_all("R1", 4'b0001, idx4(5, 0, 0, 0), 1'b0, 1'b0);
    endtask

    task automatic t_triple();
        apply(run(10, 12));
        chk_all("R2", 4'b0001, idx4(11, 0, 0, 0), 1'b0, 1'b0);
    endtask

    task automatic t_bad();
        apply(run(3, 3));
        chk_all("R3", 4'b0000, idx4(0, 0, 0, 0), 1'b0, 1'b1);
        apply(run(20, 23));
        chk_all("R3", 4'b0000, idx4(0, 0, 0, 0), 1'b0, 1'b1);
        apply(run(17, 17) | run(8, 9));
        chk_all("R3", 4'b0001, idx4(8, 0, 0, 0), 1'b0, 1'b1);
        apply('1);
        chk_all("R3", 4'b0000, idx4(0, 0, 0, 0), 1'b0, 1'b1);
        apply('0);
        chk_all("R3", 4'b0000, idx4(0, 0, 0, 0), 1'b0, 1'b0);
    endtask

    task automatic t_edges();
        apply(run(0, 1));
        chk_all("R8", 4'b0001, idx4(0, 0, 0, 0), 1'b0, 1'b0);
        apply(run(29, 31));
        chk_all("R8", 4'b0001, idx4(30, 0, 0, 0), 1'b0, 1'b0);
        apply(run(30, 31));
        chk_all("R8", 4'b0001, idx4(30, 0, 0, 0), 1'b0, 1'b0);
        apply(run(31, 31));
        chk_all("R8", 4'b0000, idx4(0, 0, 0, 0), 1'b0, 1'b1);
        apply(run(0, 0));
        chk_all("R8", 4'b0000, idx4(0, 0, 0, 0), 1'b0, 1'b1);
    endtask

    task automatic t_order();
        apply(run(25, 26) | run(2, 4) | run(14, 15));
        chk_all("R4", 4'b0111, idx4(3, 14, 25, 0), 1'b0, 1'b0);
    endtask

    task automatic t_overflow();
        apply(run(0, 1) | run(4, 6) | run(9, 10) | run(13, 14) | run(17, 18));
        chk_all("R5", 4'b1111, idx4(0, 5, 9, 13), 1'b1, 1'b0);
        apply(run(0, 1) | run(4, 6) | run(9, 10) | run(13, 14));
        chk_all("R5", 4'b1111, idx4(0, 5, 9, 13), 1'b0, 1'b0);
    endtask

    task automatic t_latency_hold();
        @(negedge clk);
        strip_bits = run(7, 8);
        in_valid   = 1'b1;
        #1;
        chk("R6", "early out_valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        in_valid   = 1'b0;
        strip_bits = run(20, 21);
        chk_all("R6", 4'b0001, idx4(7, 0, 0, 0), 1'b0, 1'b0);
        @(negedge clk);
        chk("R9", "out_valid", 64'(out_valid), 64'd0);
        chk("R9", "hit_valid", 64'(hit_valid), 64'd1);
        chk("R9", "hit_index", 64'(hit_index), 64'(idx4(7, 0, 0, 0)));
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        strip_bits = run(1, 2);
        in_valid   = 1'b1;
        @(negedge clk);
        strip_bits = run(12, 14);
        chk_all("R6", 4'b0001, idx4(1, 0, 0, 0), 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk_all("R6", 4'b0001, idx4(13, 0, 0, 0), 1'b0, 1'b0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pair();
        t_triple();
        t_bad();
        t_edges();
        t_order();
        t_overflow();
        t_latency_hold();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule